// File: doc/BRIEF.md
# Prioritized Vector Interrupt Controller

This block gathers 32 level-sensitive interrupt lines together with 32 software-raised interrupt bits. It masks the combined set with an enable word and chooses one winner by a priority level that software programs for each source. Every source owns a configuration word. That word carries its level, a flag that requests a non-maskable entry, and the number of the shadow register bank the handler should run in.

For the winner, the block computes a handler address from a programmable table base and a power-of-two vector spacing. It drives a registered request packet to the processor: handler address, register bank, level and the non-maskable flag, together with a valid line. Software reaches all state through a 32-bit word-addressed CSR port with a single-cycle write strobe and reads that return one cycle later. Acknowledge and nesting are the processor's concern.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Reset clears every stored word, drives all packet outputs and the valid line to 0, and makes every CSR read return 0.
- R2: Word offsets: 0..31 per-source config, 32 enable, 33 enable-set, 34 enable-clear, 35 pending, 36 raw input status, 37 software bits, 38 software-set, 39 software-clear, 40 global config, 41 status, 42 table base, 43 vector address. A config word holds the level in bits 5:0, the non-maskable flag in bit 6 and the register bank in bits 12:7; bits above 12 read back as 0. The global config stores bits 2:0 only.
- R3: The raw status word is the input lines sampled on each clock. Pending reads as (raw OR software bits) AND enable.
- R4: A pending source whose level is 0 never wins; with no candidate of nonzero level the valid line stays low.
- R5: The pending source with the strictly greatest level wins; on equal levels the lower index wins.
- R6: The handler address is winner index shifted left by (2 + global config bits 2:0), plus the table base.
- R7: With a winner, status reads as the index with bit 31 set and the vector address reads as the handler address. Without one, both read 0.
- R8: Set writes OR the data into enable or software bits. Clear writes remove the bits that are 1 in the data. Direct writes replace the word.
- R9: The packet carries the winner's handler address, register bank, level and flag. The valid line and packet change one clock after the edge that updates a register or samples an input.
- R10: Reads of set, clear or unmapped offsets return 0. Writes to pending, raw, status, vector address or unmapped offsets change nothing.
- R11: Read data appears on the clock edge that samples the read strobe and returns to 0 when no read is strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqLines | input | 32 | Level-sensitive interrupt inputs |
| csrAddr | input | 6 | CSR word address |
| csrWrEn | input | 1 | Write strobe, one cycle per write |
| csrWrData | input | 32 | Write data |
| csrRdEn | input | 1 | Read strobe |
| csrRdData | output | 32 | Read data, one cycle after the strobe |
| reqValid | output | 1 | Request packet valid |
| reqHandler | output | 32 | Requested handler address |
| reqRegSet | output | 6 | Requested register bank |
| reqLevel | output | 6 | Requested level |
| reqNmi | output | 1 | Requested non-maskable entry |

## Verification
The hardest condition to reach from the ports is a selection decided by the tie rule or by a zero level, while other sources are pending through a different path. That happens when a hardware line and a software bit compete and enable hides part of the set. The bench first loads a sparse configuration with two equal levels, one zero-level source and one top-level source. A vector table then drives mixes of input lines, software bits and enable masks, so each winner differs from what a fixed index order or an unmasked scan would pick. It also checks the one-clock delay of the packet after an enable write, by sampling on both sides of that edge.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
  localparam int NUM_SRC = 32;
  localparam int DATA_W  = 32;
  localparam int LVL_W   = 6;
  localparam int RS_W    = 6;
  localparam int ADDR_W  = 6;
  localparam int SEL_W   = 3;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int NMI_BIT = LVL_W;
  localparam int RS_LSB  = LVL_W + 1;
  localparam int CFG_W   = LVL_W + 1 + RS_W;

  localparam int OFF_ENABLE = 32;
  localparam int OFF_EN_SET = 33;
  localparam int OFF_EN_CLR = 34;
  localparam int OFF_PEND   = 35;
  localparam int OFF_RAW    = 36;
  localparam int OFF_SW     = 37;
  localparam int OFF_SW_SET = 38;
  localparam int OFF_SW_CLR = 39;
  localparam int OFF_GCFG   = 40;
  localparam int OFF_STATUS = 41;
  localparam int OFF_BASE   = 42;
  localparam int OFF_VADDR  = 43;

  typedef enum logic [3:0] {
    RD_NONE, RD_CFG, RD_ENABLE, RD_PEND, RD_RAW, RD_SW,
    RD_GCFG, RD_STATUS, RD_BASE, RD_VADDR
  } rdSel_e;

  typedef struct packed {
    logic             wrCfg;
    logic             wrEnable;
    logic             setEnable;
    logic             clrEnable;
    logic             wrSw;
    logic             setSw;
    logic             clrSw;
    logic             wrGcfg;
    logic             wrBase;
    logic [IDX_W-1:0] cfgIdx;
  } csrStrobe_t;
endpackage

// File: rtl/irq_vector_decode.sv
module irq_vector_decode
  import irq_vector_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              csrWrEn,
  input  logic              csrRdEn,
  output csrStrobe_t        strobe,
  output rdSel_e            rdSel
);
  rdSel_e selRaw;

  always_comb begin
    strobe        = '0;
    strobe.cfgIdx = csrAddr[IDX_W-1:0];
    selRaw        = RD_NONE;
    if (csrAddr < ADDR_W'(NUM_SRC)) begin
      strobe.wrCfg = csrWrEn;
      selRaw       = RD_CFG;
    end else begin
      case (csrAddr)
        ADDR_W'(OFF_ENABLE): begin strobe.wrEnable  = csrWrEn; selRaw = RD_ENABLE; end
        ADDR_W'(OFF_EN_SET): strobe.setEnable = csrWrEn;
        ADDR_W'(OFF_EN_CLR): strobe.clrEnable = csrWrEn;
        ADDR_W'(OFF_PEND):   selRaw = RD_PEND;
        ADDR_W'(OFF_RAW):    selRaw = RD_RAW;
        ADDR_W'(OFF_SW):     begin strobe.wrSw = csrWrEn; selRaw = RD_SW; end
        ADDR_W'(OFF_SW_SET): strobe.setSw = csrWrEn;
        ADDR_W'(OFF_SW_CLR): strobe.clrSw = csrWrEn;
        ADDR_W'(OFF_GCFG):   begin strobe.wrGcfg = csrWrEn; selRaw = RD_GCFG; end
        ADDR_W'(OFF_STATUS): selRaw = RD_STATUS;
        ADDR_W'(OFF_BASE):   begin strobe.wrBase = csrWrEn; selRaw = RD_BASE; end
        ADDR_W'(OFF_VADDR):  selRaw = RD_VADDR;
        default:             selRaw = RD_NONE;
      endcase
    end
    rdSel = csrRdEn ? selRaw : RD_NONE;
  end

  // R2: one address selects at most one register write
  assert_single_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.wrCfg, strobe.wrEnable, strobe.setEnable, strobe.clrEnable,
              strobe.wrSw, strobe.setSw, strobe.clrSw, strobe.wrGcfg, strobe.wrBase}));
  // R10: no write strobe without the bus write strobe
  assert_no_spurious_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !csrWrEn |-> !(strobe.wrCfg | strobe.wrEnable | strobe.setEnable | strobe.clrEnable |
                   strobe.wrSw | strobe.setSw | strobe.clrSw | strobe.wrGcfg | strobe.wrBase));
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import irq_vector_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0]             pending,
  input  logic [NUM_SRC-1:0][LVL_W-1:0]  levels,
  output logic                           found,
  output logic [IDX_W-1:0]               winIdx,
  output logic [LVL_W-1:0]               winLevel
);
  always_comb begin
    winIdx   = '0;
    winLevel = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pending[i] && (levels[i] > winLevel)) begin
        winIdx   = IDX_W'(i);
        winLevel = levels[i];
      end
    end
    found = (winLevel != '0);
  end

  // R5: the chosen source is among the pending ones
  assert_winner_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> pending[winIdx]);
  // R4: nothing is chosen when no source is pending
  assert_idle_when_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> !found);
endmodule

// File: rtl/irq_vector_datapath.sv
module irq_vector_datapath
  import irq_vector_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] irqLines,
  input  csrStrobe_t        strobe,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] csrWrData,
  output logic [DATA_W-1:0] csrRdData,
  output logic              reqValid,
  output logic [DATA_W-1:0] reqHandler,
  output logic [RS_W-1:0]   reqRegSet,
  output logic [LVL_W-1:0]  reqLevel,
  output logic              reqNmi
);
  logic [NUM_SRC-1:0][CFG_W-1:0] cfgQ;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvlVec;
  logic [NUM_SRC-1:0] enableQ, swQ, rawQ, pending;
  logic [SEL_W-1:0]   gcfgQ;
  logic [DATA_W-1:0]  baseQ, handler, statusW, vaddrW, rdMux;
  logic [SEL_W:0]     shAmt;
  logic               found, armedQ;
  logic [IDX_W-1:0]   winIdx;
  logic [LVL_W-1:0]   winLevel;
  logic [CFG_W-1:0]   winCfg;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
    assign lvlVec[g] = cfgQ[g][LVL_W-1:0];
  end

  assign pending = (rawQ | swQ) & enableQ;

  irq_vector_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .pending(pending), .levels(lvlVec),
    .found(found), .winIdx(winIdx), .winLevel(winLevel)
  );

  assign shAmt   = {1'b0, gcfgQ} + (SEL_W+1)'(2);
  assign handler = (DATA_W'(winIdx) << shAmt) + baseQ;
  assign winCfg  = cfgQ[winIdx];
  assign statusW = found ? {1'b1, (DATA_W-1-IDX_W)'(0), winIdx} : '0;
  assign vaddrW  = found ? handler : '0;

  always_comb begin
    case (rdSel)
      RD_CFG:    rdMux = DATA_W'(cfgQ[strobe.cfgIdx]);
      RD_ENABLE: rdMux = enableQ;
      RD_PEND:   rdMux = pending;
      RD_RAW:    rdMux = rawQ;
      RD_SW:     rdMux = swQ;
      RD_GCFG:   rdMux = DATA_W'(gcfgQ);
      RD_STATUS: rdMux = statusW;
      RD_BASE:   rdMux = baseQ;
      RD_VADDR:  rdMux = vaddrW;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgQ <= '0; enableQ <= '0; swQ <= '0; rawQ <= '0; gcfgQ <= '0; baseQ <= '0;
      csrRdData <= '0; reqValid <= 1'b0; reqHandler <= '0; reqRegSet <= '0;
      reqLevel <= '0; reqNmi <= 1'b0; armedQ <= 1'b0;
    end else begin
      armedQ <= 1'b1;
      rawQ   <= irqLines;
      if (strobe.wrCfg) cfgQ[strobe.cfgIdx] <= csrWrData[CFG_W-1:0];
      if (strobe.wrEnable)       enableQ <= csrWrData;
      else if (strobe.setEnable) enableQ <= enableQ | csrWrData;
      else if (strobe.clrEnable) enableQ <= enableQ & ~csrWrData;
      if (strobe.wrSw)       swQ <= csrWrData;
      else if (strobe.setSw) swQ <= swQ | csrWrData;
      else if (strobe.clrSw) swQ <= swQ & ~csrWrData;
      if (strobe.wrGcfg) gcfgQ <= csrWrData[SEL_W-1:0];
      if (strobe.wrBase) baseQ <= csrWrData;
      csrRdData  <= rdMux;
      reqValid   <= found;
      reqHandler <= vaddrW;
      reqLevel   <= winLevel;
      reqRegSet  <= found ? winCfg[RS_LSB +: RS_W] : '0;
      reqNmi     <= found & winCfg[NMI_BIT];
    end
  end

  // R8: set write ORs into enable
  assert_enable_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armedQ && $past(strobe.setEnable)) |-> enableQ == ($past(enableQ) | $past(csrWrData)));
  // R8: clear write removes software bits
  assert_sw_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armedQ && $past(strobe.clrSw)) |-> swQ == ($past(swQ) & ~$past(csrWrData)));
  // R4: a valid request never carries level 0
  assert_valid_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> reqLevel != '0);
  // R7: no pending source in the previous cycle means no request now
  assert_idle_no_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armedQ && $past(pending) == '0) |-> !reqValid);
  // R9: an idle request carries an all-zero packet
  assert_idle_packet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |-> (reqHandler == '0 && reqLevel == '0 && !reqNmi && reqRegSet == '0));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vector_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irqLines,
  input  logic [ADDR_W-1:0]  csrAddr,
  input  logic               csrWrEn,
  input  logic [DATA_W-1:0]  csrWrData,
  input  logic               csrRdEn,
  output logic [DATA_W-1:0]  csrRdData,
  output logic               reqValid,
  output logic [DATA_W-1:0]  reqHandler,
  output logic [RS_W-1:0]    reqRegSet,
  output logic [LVL_W-1:0]   reqLevel,
  output logic               reqNmi
);
  csrStrobe_t strobe;
  rdSel_e     rdSel;

  irq_vector_decode u_dec (
    .clk(clk), .rst_n(rst_n), .csrAddr(csrAddr), .csrWrEn(csrWrEn),
    .csrRdEn(csrRdEn), .strobe(strobe), .rdSel(rdSel)
  );

  irq_vector_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .irqLines(irqLines), .strobe(strobe), .rdSel(rdSel),
    .csrWrData(csrWrData), .csrRdData(csrRdData), .reqValid(reqValid),
    .reqHandler(reqHandler), .reqRegSet(reqRegSet), .reqLevel(reqLevel), .reqNmi(reqNmi)
  );
endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irqLines = '0;
  logic [5:0]  csrAddr = '0;
  logic        csrWrEn = 1'b0;
  logic [31:0] csrWrData = '0;
  logic        csrRdEn = 1'b0;
  logic [31:0] csrRdData, reqHandler;
  logic        reqValid, reqNmi;
  logic [5:0]  reqRegSet, reqLevel;
  int          nTests = 0;
  int          nFail = 0;
  logic [2:0]  gsel = 3'd3;
  logic [31:0] base = 32'h0000_1000;

  always #2.5 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irqLines(irqLines), .csrAddr(csrAddr), .csrWrEn(csrWrEn),
    .csrWrData(csrWrData), .csrRdEn(csrRdEn), .csrRdData(csrRdData), .reqValid(reqValid),
    .reqHandler(reqHandler), .reqRegSet(reqRegSet), .reqLevel(reqLevel), .reqNmi(reqNmi)
  );

  typedef struct packed {
    logic [31:0] irq;
    logic [31:0] sw;
    logic [31:0] en;
    logic        expValid;
    logic [4:0]  expIdx;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{32'h0000_0000, 32'h0, 32'hFFFF_FFFF, 1'b0, 5'd0},
    '{32'h0000_0008, 32'h0, 32'hFFFF_FFFF, 1'b1, 5'd3},
    '{32'h0000_0088, 32'h0, 32'hFFFF_FFFF, 1'b1, 5'd3},
    '{32'h0000_0480, 32'h0, 32'hFFFF_FFFF, 1'b1, 5'd10},
    '{32'h0000_0020, 32'h0, 32'hFFFF_FFFF, 1'b0, 5'd0},
    '{32'h0010_0020, 32'h0, 32'hFFFF_FFFF, 1'b1, 5'd20},
    '{32'h0000_0000, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 5'd31},
    '{32'h0000_0400, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 5'd10},
    '{32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 1'b1, 5'd31},
    '{32'hFFFF_FFFF, 32'h0, 32'h0000_0000, 1'b0, 5'd0},
    '{32'h0000_0080, 32'h0000_0008, 32'h0000_0080, 1'b1, 5'd7}
  };

  // Bench configuration: bank in 12:7, flag in 6, level in 5:0
  function automatic logic [31:0] cfgOf(int i);
    case (i)
      3:  return (32'd2 << 7) | (32'd1 << 6) | 32'd5;
      7:  return (32'd9 << 7) | 32'd5;
      10: return (32'd1 << 7) | 32'd12;
      20: return 32'd1;
      31: return (32'd63 << 7) | (32'd1 << 6) | 32'd63;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] handlerOf(int idx);
    return (32'(idx) << (32'd2 + 32'(gsel))) + base;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csrWrite(int addr, logic [31:0] data);
    @(negedge clk);
    csrAddr = 6'(addr); csrWrData = data; csrWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    csrWrEn = 1'b0;
  endtask

  task automatic csrRead(int addr, output logic [31:0] data);
    @(negedge clk);
    csrAddr = 6'(addr); csrRdEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    csrRdEn = 1'b0;
    data = csrRdData;
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    check("R1 valid in reset", 32'(reqValid), 32'd0);
    check("R1 handler in reset", reqHandler, 32'd0);
    rst_n = 1'b1;
    csrRead(32, rd); check("R1 enable after reset", rd, 32'd0);
    csrRead(3, rd);  check("R1 config after reset", rd, 32'd0);
    csrRead(42, rd); check("R1 base after reset", rd, 32'd0);

    for (int i = 0; i < 32; i++) csrWrite(i, cfgOf(i));
    csrWrite(40, 32'(gsel));
    csrWrite(42, base);

    // R2: config layout and upper bits
    csrRead(31, rd); check("R2 config readback", rd, cfgOf(31));
    csrWrite(12, 32'hFFFF_FFFF);
    csrRead(12, rd); check("R2 config upper bits", rd, 32'h0000_1FFF);
    csrWrite(12, 32'h0);
    csrWrite(40, 32'hFFFF_FFF3);
    csrRead(40, rd); check("R2 global config width", rd, 32'd3);

    // Vector table: R3 R4 R5 R6 R7 R9
    for (int v = 0; v < 11; v++) begin
      @(negedge clk); irqLines = VECS[v].irq;
      csrWrite(37, VECS[v].sw);
      csrWrite(32, VECS[v].en);
      settle();
      check($sformatf("R5 vec%0d valid", v), 32'(reqValid), 32'(VECS[v].expValid));
      if (VECS[v].expValid) begin
        check($sformatf("R6 vec%0d handler", v), reqHandler, handlerOf(int'(VECS[v].expIdx)));
        check($sformatf("R9 vec%0d level", v), 32'(reqLevel), cfgOf(int'(VECS[v].expIdx)) & 32'h3F);
        check($sformatf("R9 vec%0d bank", v), 32'(reqRegSet), (cfgOf(int'(VECS[v].expIdx)) >> 7) & 32'h3F);
        check($sformatf("R9 vec%0d flag", v), 32'(reqNmi), (cfgOf(int'(VECS[v].expIdx)) >> 6) & 32'h1);
        csrRead(41, rd); check($sformatf("R7 vec%0d status", v), rd, 32'h8000_0000 | 32'(VECS[v].expIdx));
        csrRead(43, rd); check($sformatf("R7 vec%0d vaddr", v), rd, handlerOf(int'(VECS[v].expIdx)));
      end else begin
        check($sformatf("R4 vec%0d handler", v), reqHandler, 32'd0);
        csrRead(41, rd); check($sformatf("R7 vec%0d status idle", v), rd, 32'd0);
        csrRead(43, rd); check($sformatf("R7 vec%0d vaddr idle", v), rd, 32'd0);
      end
    end

    // R3: raw and pending words
    @(negedge clk); irqLines = 32'h0000_00A5;
    csrWrite(37, 32'h0000_0100);
    csrWrite(32, 32'h0000_010F);
    csrRead(36, rd); check("R3 raw status", rd, 32'h0000_00A5);
    csrRead(35, rd); check("R3 pending", rd, 32'h0000_0105);

    // R8: set and clear
    csrWrite(32, 32'h0000_000F);
    csrWrite(33, 32'h0000_00F0);
    csrRead(32, rd); check("R8 enable set", rd, 32'h0000_00FF);
    csrWrite(34, 32'h0000_000F);
    csrRead(32, rd); check("R8 enable clear", rd, 32'h0000_00F0);
    csrWrite(37, 32'h0000_0003);
    csrWrite(38, 32'h0000_0100);
    csrWrite(39, 32'h0000_0001);
    csrRead(37, rd); check("R8 software set/clear", rd, 32'h0000_0102);

    // R10: write-only and unmapped reads, ignored writes
    csrRead(33, rd); check("R10 read enable-set", rd, 32'd0);
    csrRead(39, rd); check("R10 read sw-clear", rd, 32'd0);
    csrRead(50, rd); check("R10 read unmapped", rd, 32'd0);
    csrRead(35, rd); check("R10 pending before write", rd, 32'h0000_00A0);
    csrWrite(35, 32'hFFFF_FFFF);
    csrWrite(36, 32'hFFFF_FFFF);
    csrWrite(60, 32'hFFFF_FFFF);
    csrRead(35, rd); check("R10 pending after writes", rd, 32'h0000_00A0);
    csrRead(32, rd); check("R10 enable untouched", rd, 32'h0000_00F0);
    csrRead(40, rd); check("R10 global config untouched", rd, 32'd3);

    // R6: spacing extremes
    @(negedge clk); irqLines = 32'h0000_0400;
    csrWrite(37, 32'h0);
    csrWrite(32, 32'h0000_0400);
    gsel = 3'd0; csrWrite(40, 32'd0); settle();
    check("R6 spacing 4", reqHandler, handlerOf(10));
    gsel = 3'd7; csrWrite(40, 32'd7); settle();
    check("R6 spacing 512", reqHandler, handlerOf(10));

    // R9: packet lags the enable write by one clock
    csrWrite(32, 32'h0); settle();
    @(negedge clk);
    csrAddr = 6'd32; csrWrData = 32'h0000_0400; csrWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    csrWrEn = 1'b0;
    check("R9 valid not yet", 32'(reqValid), 32'd0);
    @(posedge clk); @(negedge clk);
    check("R9 valid one clock later", 32'(reqValid), 32'd1);

    // R11: read data lasts one cycle
    csrRead(42, rd); check("R11 read data", rd, base);
    @(negedge clk);
    check("R11 read data cleared", csrRdData, 32'd0);

    // R1: reset in the middle of operation
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 valid after mid reset", 32'(reqValid), 32'd0);
    rst_n = 1'b1;
    csrRead(31, rd); check("R1 config after mid reset", rd, 32'd0);
    csrRead(32, rd); check("R1 enable after mid reset", rd, 32'd0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule